// File: doc/BRIEF.md
# Processor Clock Source Selector and Divider

This block makes the processor clock from two free-running sources: a fast PLL clock and a slower crystal clock. An input selector chooses which source feeds a programmable divider. The divider can pass its source straight through, divide it by two or three, or divide it by any even ratio 2N. An output selector then chooses between the divider result and the raw crystal. The crystal bypass lets the processor keep running while the PLL is being retuned.

The whole block runs in one fast reference clock domain. Both source clocks are sampled as levels, and every clock the block produces is a registered level in that domain. Each selector changes source with a handshake. It waits until the old source is low, holds its output low, and only lets the new source through once that source is also low. The divider counts both edges of its source, so every ratio gives a 50 % duty cycle. A new ratio is picked up only when the divided clock falls at the end of a period.

Two registers on a simple write-strobe bus with a combinational read path hold the settings.

Top module: `cpuclk_gen`

## Requirements
- R1: After reset both registers read 0. The output follows the crystal, and its high and low phases each last one crystal half-period.
- R2: The register at address 0x00 holds the 9-bit N field in bits 28:20. The register at address 0x40 holds the input-select bit in bit 0, the 2-bit ratio select in bits 3:2 and the output-select bit in bit 7. All other bits read 0. A write to any other address changes nothing, and any other address reads 0.
- R3: With the output-select bit at 0, the output is the crystal, whatever the other settings are.
- R4: The input-select bit chooses the divider source: 1 is the PLL and 0 is the crystal.
- R5: Ratio select values 0, 1 and 2 divide the source by 1, 2 and 3.
- R6: Ratio select 3 with N of 1 or more divides the source by 2N.
- R7: For every ratio D, the divided clock stays high for D source half-periods and low for D source half-periods.
- R8: Ratio select 3 with N equal to 0 holds the divided clock low.
- R9: A new ratio takes effect only where the divided clock falls. A high phase that is already running keeps its old length.
- R10: Switching either selector produces no high or low phase shorter than the shortest half-period of the sources. While a selector is between sources, its output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; all logic is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pll_clk_i | input | 1 | PLL source clock, sampled as a level |
| xtal_clk_i | input | 1 | Crystal source clock, sampled as a level |
| cpu_clk_o | output | 1 | Generated processor clock |

## Verification
Assertions check several properties on every cycle:
- a selector that is between sources drives its output low, and it only takes on a new source from that parked state;
- the divider's count stays below the active ratio, and a stopped divider (select 3 with N of 0) stays low;
- the active ratio changes only on a falling edge of the divided clock;
- a write to an unmapped address leaves both registers unchanged.

Other behaviours only the bench scenarios can show. These are the real output period and duty cycle for each source, ratio and N, and the fact that a write landing mid-phase does not shorten the running high phase. They also include the absence of short pulses across many random selector changes, which the bench measures as run lengths at the output pin.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int DATA_W  = 32;
    localparam int N_W     = 9;
    localparam int N_LSB   = 20;
    localparam int SEL_W   = 2;
    localparam int SEL_LSB = 2;
    localparam int IN_BIT  = 0;
    localparam int OUT_BIT = 7;
    localparam int CNT_W   = N_W + 1;

    localparam int ADDR_DIVN = 'h00;
    localparam int ADDR_CTRL = 'h40;

    localparam logic [DATA_W-1:0] DIVN_MASK =
        ((DATA_W'(1) << N_W) - DATA_W'(1)) << N_LSB;
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << OUT_BIT) |
        (((DATA_W'(1) << SEL_W) - DATA_W'(1)) << SEL_LSB) |
        (DATA_W'(1) << IN_BIT);

    typedef enum logic {
        SW_RUN  = 1'b0,
        SW_PARK = 1'b1
    } sw_state_e;

    typedef struct packed {
        logic             out_sel;
        logic             in_sel;
        logic [SEL_W-1:0] div_sel;
        logic [N_W-1:0]   n;
    } clk_ctrl_t;

    // Number of source half-periods per divided-clock phase; 0 means stopped.
    function automatic logic [CNT_W-1:0] div_ratio(input logic [SEL_W-1:0] sel,
                                                   input logic [N_W-1:0]   n);
        logic [CNT_W-1:0] r;
        case (sel)
            2'd0:    r = CNT_W'(1);
            2'd1:    r = CNT_W'(2);
            2'd2:    r = CNT_W'(3);
            default: r = {n, 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
    import cpuclk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output clk_ctrl_t         ctrl_o
);

    logic [DATA_W-1:0] divn_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              hit_divn;
    logic              hit_ctrl;

    assign hit_divn = (addr_i == ADDR_W'(ADDR_DIVN));
    assign hit_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));

    always_ff @(posedge clk) begin
        if (rst) begin
            divn_q <= '0;
            ctrl_q <= '0;
        end else if (we_i) begin
            if (hit_divn) divn_q <= wdata_i & DIVN_MASK;
            if (hit_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
        end
    end

    always_comb begin
        if (hit_divn)      rdata_o = divn_q;
        else if (hit_ctrl) rdata_o = ctrl_q;
        else               rdata_o = '0;
    end

    assign ctrl_o.n       = divn_q[N_LSB +: N_W];
    assign ctrl_o.div_sel = ctrl_q[SEL_LSB +: SEL_W];
    assign ctrl_o.in_sel  = ctrl_q[IN_BIT];
    assign ctrl_o.out_sel = ctrl_q[OUT_BIT];

    // R2: writes to unmapped addresses leave both registers untouched
    p_unmapped_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (we_i && !hit_divn && !hit_ctrl) |=> ($stable(divn_q) && $stable(ctrl_q)))
        else $error("unmapped write changed a register");

endmodule

// File: rtl/cpuclk_glitchless_sel.sv
module cpuclk_glitchless_sel
    import cpuclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_i,     // source for sel_i == 0
    input  logic b_i,     // source for sel_i == 1
    input  logic sel_i,
    output logic y_o
);

    sw_state_e st_q;
    logic      cur_q;
    logic      old_src;
    logic      new_src;

    assign old_src = cur_q ? b_i : a_i;
    assign new_src = sel_i ? b_i : a_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SW_RUN;
            cur_q <= 1'b0;
            y_o   <= 1'b0;
        end else begin
            case (st_q)
                SW_RUN: begin
                    if (sel_i != cur_q && !old_src) begin
                        st_q <= SW_PARK;
                        y_o  <= 1'b0;
                    end else begin
                        y_o  <= old_src;
                    end
                end
                default: begin
                    y_o <= 1'b0;
                    if (!new_src) begin
                        cur_q <= sel_i;
                        st_q  <= SW_RUN;
                    end
                end
            endcase
        end
    end

    // R10: output is held low while parked between sources
    p_park_low_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == SW_PARK) |=> !y_o)
        else $error("selector output high while parked");

    // R10: the active source only changes on leaving the parked state
    p_switch_from_park_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_q) |-> ($past(st_q) == SW_PARK))
        else $error("selector source changed outside park");

    // R10: parking begins only while the old source is low
    p_enter_park_low_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == SW_RUN && sel_i != cur_q && old_src) |=> (st_q == SW_RUN))
        else $error("selector parked while old source high");

endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
    import cpuclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             src_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic [N_W-1:0]   n_i,
    output logic             clk_o
);

    logic             src_q;
    logic             src_edge;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] ratio_req;

    assign ratio_req = div_ratio(div_sel_i, n_i);
    assign src_edge  = src_i ^ src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= 1'b0;
            cnt_q   <= '0;
            ratio_q <= CNT_W'(1);
            clk_o   <= 1'b0;
        end else begin
            src_q <= src_i;
            if (ratio_q == '0) begin
                clk_o <= 1'b0;
                cnt_q <= '0;
                if (src_edge) ratio_q <= ratio_req;
            end else if (src_edge) begin
                if (cnt_q == ratio_q - CNT_W'(1)) begin
                    cnt_q <= '0;
                    clk_o <= ~clk_o;
                    if (clk_o) ratio_q <= ratio_req;   // end of a full period
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R8: a stopped divider drives its clock low
    p_stopped_low_r8: assert property (@(posedge clk) disable iff (rst)
        (ratio_q == '0) |=> !clk_o)
        else $error("stopped divider clock not low");

    // R9: the active ratio only changes where the divided clock falls
    p_ratio_at_period_end_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ratio_q) && $past(ratio_q) != '0) |-> $fell(clk_o))
        else $error("ratio changed mid-period");

    // R7: the half-period counter stays inside the active ratio
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (ratio_q != '0) |-> (cnt_q < ratio_q))
        else $error("divider count out of range");

    // R7: the divided clock only moves on a source edge
    p_toggle_on_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (!src_edge && ratio_q != '0) |=> $stable(clk_o))
        else $error("divided clock moved without a source edge");

endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
    import cpuclk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pll_clk_i,
    input  logic              xtal_clk_i,
    output logic              cpu_clk_o
);

    clk_ctrl_t ctrl;
    logic      pll_s;
    logic      xtal_s;
    logic      div_src;
    logic      div_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_s  <= 1'b0;
            xtal_s <= 1'b0;
        end else begin
            pll_s  <= pll_clk_i;
            xtal_s <= xtal_clk_i;
        end
    end

    cpuclk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .ctrl_o  (ctrl)
    );

    cpuclk_glitchless_sel u_src_sel (
        .clk   (clk),
        .rst   (rst),
        .a_i   (xtal_s),
        .b_i   (pll_s),
        .sel_i (ctrl.in_sel),
        .y_o   (div_src)
    );

    cpuclk_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .src_i     (div_src),
        .div_sel_i (ctrl.div_sel),
        .n_i       (ctrl.n),
        .clk_o     (div_clk)
    );

    cpuclk_glitchless_sel u_out_sel (
        .clk   (clk),
        .rst   (rst),
        .a_i   (xtal_s),
        .b_i   (div_clk),
        .sel_i (ctrl.out_sel),
        .y_o   (cpu_clk_o)
    );

endmodule

// File: tb/cpuclk_gen_test.sv
module cpuclk_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int PLL_HALF   = 2;
    localparam int XTAL_HALF  = 5;
    localparam int SETTLE     = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_clk_i = 1'b0;
    logic        xtal_clk_i = 1'b0;
    logic        cpu_clk_o;

    int checks = 0;
    int fails = 0;
    int short_runs = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    cpuclk_gen #(.ADDR_W(8)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_clk_i(pll_clk_i), .xtal_clk_i(xtal_clk_i), .cpu_clk_o(cpu_clk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        repeat (PLL_HALF) @(negedge clk);
        pll_clk_i = ~pll_clk_i;
    end

    initial forever begin
        repeat (XTAL_HALF) @(negedge clk);
        xtal_clk_i = ~xtal_clk_i;
    end

    // Run-length monitor for R10: no phase shorter than the shortest source half
    initial begin
        int  run;
        bit  prev;
        bit  seen;
        run = 0; prev = 1'b0; seen = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (cpu_clk_o != prev) begin
                    if (seen && run < PLL_HALF) short_runs++;
                    seen = 1'b1;
                    run  = 1;
                    prev = cpu_clk_o;
                end else begin
                    run++;
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        hi = 0; lo = 0; g = 0;
        while (cpu_clk_o !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
        while (cpu_clk_o !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        while (cpu_clk_o === 1'b1 && g < 4000) begin hi++; @(negedge clk); g++; end
        while (cpu_clk_o === 1'b0 && g < 4000) begin lo++; @(negedge clk); g++; end
    endtask

    function automatic int exp_half(input bit in_s, input bit out_s,
                                    input int sel, input int n);
        int src;
        int d;
        if (!out_s) return XTAL_HALF;
        src = in_s ? PLL_HALF : XTAL_HALF;
        d = (sel < 3) ? sel + 1 : 2 * n;
        return src * d;
    endfunction

    task automatic configure(input bit in_s, input bit out_s, input int sel, input int n);
        bus_write(8'h00, 32'(n) << 20);
        bus_write(8'h40, (32'(out_s) << 7) | (32'(sel) << 2) | 32'(in_s));
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic run_case(input string req, input bit in_s, input bit out_s,
                            input int sel, input int n);
        int hi;
        int lo;
        int e;
        configure(in_s, out_s, sel, n);
        measure(hi, lo);
        e = exp_half(in_s, out_s, sel, n);
        check({req, " high"}, hi, e);
        check({req, " low"}, lo, e);
    endtask

    initial begin
        logic [31:0] rd;
        int hi;
        int lo;
        int highs;
        void'($urandom(32'd20240607));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;

        // R1: reset state
        bus_read(8'h00, rd); check("R1 divn reset", int'(rd), 0);
        bus_read(8'h40, rd); check("R1 ctrl reset", int'(rd), 0);
        repeat (50) @(negedge clk);
        measure(hi, lo);
        check("R1 high", hi, XTAL_HALF);
        check("R1 low", lo, XTAL_HALF);

        // R2: field masks, unmapped address
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, rd); check("R2 divn mask", int'(rd), int'(32'h1FF0_0000));
        bus_write(8'h40, 32'hFFFF_FF72);
        bus_read(8'h40, rd); check("R2 ctrl mask", int'(rd), int'(32'h0000_0000));
        bus_write(8'h40, 32'h0000_0000);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h40, rd); check("R2 unmapped write ignored", int'(rd), 0);
        bus_read(8'h20, rd); check("R2 unmapped read", int'(rd), 0);
        bus_write(8'h00, 32'h0);
        repeat (SETTLE) @(negedge clk);
        measure(hi, lo);
        check("R2 output after unmapped write", hi, XTAL_HALF);

        // R3: output selector at crystal overrides divider settings
        run_case("R3 bypass", 1'b1, 1'b0, 2, 0);

        // R4/R5: each fixed ratio from each source
        run_case("R4 R5 xtal div1", 1'b0, 1'b1, 0, 0);
        run_case("R4 R5 pll div1", 1'b1, 1'b1, 0, 0);
        run_case("R5 pll div2", 1'b1, 1'b1, 1, 0);
        run_case("R5 R7 pll div3", 1'b1, 1'b1, 2, 0);
        run_case("R5 R7 xtal div3", 1'b0, 1'b1, 2, 0);

        // R6: even ratios, including the smallest and a larger one
        run_case("R6 pll n1", 1'b1, 1'b1, 3, 1);
        run_case("R6 pll n5", 1'b1, 1'b1, 3, 5);

        // R8: N = 0 stops the divided clock low
        configure(1'b1, 1'b1, 3, 0);
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cpu_clk_o) highs++;
        end
        check("R8 stopped high samples", highs, 0);
        run_case("R8 restart n2", 1'b1, 1'b1, 3, 2);

        // R9: ratio written mid-high keeps the running high phase
        configure(1'b1, 1'b1, 3, 4);
        hi = 0; lo = 0;
        while (cpu_clk_o !== 1'b0) @(negedge clk);
        while (cpu_clk_o !== 1'b1) @(negedge clk);
        hi = 1;
        bus_addr = 8'h40; bus_wdata = 32'h0000_0081; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        while (cpu_clk_o === 1'b1) begin hi++; @(negedge clk); end
        while (cpu_clk_o === 1'b0) begin lo++; @(negedge clk); end
        check("R9 running high kept", hi, PLL_HALF * 8);
        check("R9 new ratio low", lo, PLL_HALF);

        // Random mix over sources, ratios and selectors (R4 R5 R6 R7 R10)
        for (int k = 0; k < 14; k++) begin
            bit in_s;
            bit out_s;
            int sel;
            int n;
            in_s  = 1'($urandom % 2);
            out_s = (($urandom % 4) != 0);
            sel   = int'($urandom % 4);
            n     = 1 + int'($urandom % 6);
            run_case("R7 random", in_s, out_s, sel, n);
        end

        check("R10 short phases", short_runs, 0);

        done = 1'b1;
        summary();
    end

endmodule